// File: doc/BRIEF.md
# Write Completion Status Readout

This block sits on the read path of a byte-wide nonvolatile memory that programs itself over a long, self-timed cycle. While the memory is idle it passes the array's read data to the host bus. While a program cycle is running the array cannot be read, so the block returns a status byte instead. That byte gives software two ways, independent of the busy pin, to tell when programming has finished.

The first way is polarity polling. The most significant bit of every read made during the program cycle is the inverse of that bit in the byte most recently written. When a read returns the written polarity, the cycle is over.

The second way is a toggling bit. The bit just below the polling bit changes value on each separate read access made during the cycle. Once the cycle ends, two reads in a row return the same value. The value that bit starts from and ends on is not defined, so a poller compares successive reads rather than absolute values.

The remaining low bits of the status byte are a fixed filler pattern set by a parameter. Callers should treat them as don't-care.

The block also produces the tri-state enable for the bus. That enable is decoded directly from the strobes, so the bus is released in the same cycle a strobe goes inactive.

Top module: `status_readout`

## Requirements
- R1: `rd_drive_o` is 1 exactly when `ce_n_i`=0, `oe_n_i`=0 and `we_n_i`=1, in the same cycle as those strobe values, with no register delay.
- R2: Whenever `rd_drive_o` is 0, `rd_data_o` is all zeros.
- R3: While `busy_i`=0, a driven read returns `array_data_i` unchanged on all bits. This includes the first read after a program cycle ends.
- R4: While `busy_i`=1, bit DW-1 of a driven read equals the inverse of bit DW-1 of `last_wr_data_i`.
- R5: While `busy_i`=1, bit DW-2 of each read access differs from bit DW-2 of the previous busy read access. A read access is one unbroken run of cycles with `rd_drive_o`=1.
- R6: Within one read access made while busy, bit DW-2 holds the same value on every cycle, however long the access lasts.
- R7: Read accesses made while `busy_i`=0 do not advance the toggle sequence. The first busy access after an idle period shows the inverse of bit DW-2 from the last busy access before that period.
- R8: After a synchronous reset with the strobes inactive, `rd_drive_o` is 0 and `rd_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | High while the self-timed program cycle runs |
| last_wr_data_i | input | DW | Byte most recently written by the write controller |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| array_data_i | input | DW | Read data from the storage array |
| rd_data_o | output | DW | Read data toward the bus pads |
| rd_drive_o | output | 1 | Tri-state enable for the bus pads |

## Verification
The assertions assume three things about the inputs.

- `busy_i` does not change during a read access. The toggle checks record bit DW-2 at the first cycle of an access and expect it to stay the same until that access ends.
- `last_wr_data_i` changes only between accesses.
- The strobes are inactive while reset is held.

The stimulus changes `busy_i` and the last-written byte only while the strobes are idle. It ends accesses either by raising a strobe or by pulling write-enable low, and it always leaves at least one idle cycle between two accesses so that each access has its own start.

// File: rtl/status_readout_pkg.sv
package status_readout_pkg;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_ARRAY  = 2'd1,
        SRC_STATUS = 2'd2
    } rd_src_e;

    typedef struct packed {
        logic active;
        logic start;
    } rd_phase_t;

    function automatic logic rd_strobe_ok(input logic ce_n, input logic oe_n, input logic we_n);
        return (!ce_n) && (!oe_n) && we_n;
    endfunction

    function automatic rd_src_e pick_src(input logic active, input logic busy);
        if (!active)
            return SRC_NONE;
        else if (busy)
            return SRC_STATUS;
        else
            return SRC_ARRAY;
    endfunction

endpackage

// File: rtl/sr_strobe_decode.sv
module sr_strobe_decode
    import status_readout_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ce_n_i,
    input  logic      oe_n_i,
    input  logic      we_n_i,
    output rd_phase_t phase_o
);
    logic active_now;
    logic active_q;

    assign active_now = rd_strobe_ok(ce_n_i, oe_n_i, we_n_i);

    always_ff @(posedge clk) begin
        if (rst)
            active_q <= 1'b0;
        else
            active_q <= active_now;
    end

    always_comb begin
        phase_o.active = active_now;
        phase_o.start  = active_now && !active_q;
    end
endmodule

// File: rtl/sr_toggle_track.sv
module sr_toggle_track
    import status_readout_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      busy_i,
    input  rd_phase_t phase_i,
    output logic      tog_o
);
    logic tog_q;
    logic advance;

    assign advance = phase_i.start && busy_i;

    always_ff @(posedge clk) begin
        if (rst)
            tog_q <= 1'b0;
        else if (advance)
            tog_q <= !tog_q;
    end

    // The first cycle of an access already shows the post-flip value, so the
    // bit is steady across the whole access.
    assign tog_o = tog_q ^ advance;
endmodule

// File: rtl/sr_data_mux.sv
module sr_data_mux
    import status_readout_pkg::*;
#(
    parameter int              DW          = 8,
    parameter logic [DW-1:0]   STATUS_FILL = '0
) (
    input  rd_phase_t       phase_i,
    input  logic            busy_i,
    input  logic            tog_i,
    input  logic [DW-1:0]   last_wr_data_i,
    input  logic [DW-1:0]   array_data_i,
    output logic [DW-1:0]   rd_data_o
);
    localparam int POLL_BIT = DW - 1;
    localparam int TOG_BIT  = DW - 2;

    logic [DW-1:0] status_word;
    rd_src_e       src;

    for (genvar i = 0; i < DW; i++) begin : g_status
        if (i == POLL_BIT) begin : g_poll
            assign status_word[i] = !last_wr_data_i[i];
        end else if (i == TOG_BIT) begin : g_tog
            assign status_word[i] = tog_i;
        end else begin : g_fill
            assign status_word[i] = STATUS_FILL[i];
        end
    end

    assign src = pick_src(phase_i.active, busy_i);

    always_comb begin
        unique case (src)
            SRC_ARRAY:  rd_data_o = array_data_i;
            SRC_STATUS: rd_data_o = status_word;
            default:    rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/status_readout.sv
module status_readout
    import status_readout_pkg::*;
#(
    parameter int            DW          = 8,
    parameter logic [DW-1:0] STATUS_FILL = 8'h15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy_i,
    input  logic [DW-1:0] last_wr_data_i,
    input  logic          ce_n_i,
    input  logic          oe_n_i,
    input  logic          we_n_i,
    input  logic [DW-1:0] array_data_i,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_drive_o
);
    rd_phase_t phase;
    logic      tog;

    sr_strobe_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .ce_n_i  (ce_n_i),
        .oe_n_i  (oe_n_i),
        .we_n_i  (we_n_i),
        .phase_o (phase)
    );

    sr_toggle_track u_tog (
        .clk     (clk),
        .rst     (rst),
        .busy_i  (busy_i),
        .phase_i (phase),
        .tog_o   (tog)
    );

    sr_data_mux #(.DW(DW), .STATUS_FILL(STATUS_FILL)) u_mux (
        .phase_i        (phase),
        .busy_i         (busy_i),
        .tog_i          (tog),
        .last_wr_data_i (last_wr_data_i),
        .array_data_i   (array_data_i),
        .rd_data_o      (rd_data_o)
    );

    assign rd_drive_o = phase.active;
endmodule

// File: rtl/status_readout_chk.sv
module status_readout_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          busy_i,
    input logic [DW-1:0] last_wr_data_i,
    input logic          ce_n_i,
    input logic          oe_n_i,
    input logic          we_n_i,
    input logic [DW-1:0] array_data_i,
    input logic [DW-1:0] rd_data_o,
    input logic          rd_drive_o
);
    logic prev_drive;
    logic seen;
    logic last_b6;
    logic acc_start;

    assign acc_start = rd_drive_o && !prev_drive;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_drive <= 1'b0;
            seen       <= 1'b0;
            last_b6    <= 1'b0;
        end else begin
            prev_drive <= rd_drive_o;
            if (acc_start && busy_i) begin
                seen    <= 1'b1;
                last_b6 <= rd_data_o[DW-2];
            end
        end
    end

    assert_drive_R1: assert property (@(posedge clk) disable iff (rst)
        rd_drive_o == (!ce_n_i && !oe_n_i && we_n_i));

    assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_drive_o |-> (rd_data_o == '0));

    assert_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_drive_o && !busy_i) |-> (rd_data_o == array_data_i));

    assert_poll_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_drive_o && busy_i) |-> (rd_data_o[DW-1] != last_wr_data_i[DW-1]));

    // Also covers R7, since idle accesses never update last_b6.
    assert_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_start && busy_i && seen) |-> (rd_data_o[DW-2] != last_b6));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_drive_o && busy_i && !acc_start && seen) |-> (rd_data_o[DW-2] == last_b6));
endmodule

bind status_readout status_readout_chk #(.DW(DW)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .busy_i         (busy_i),
    .last_wr_data_i (last_wr_data_i),
    .ce_n_i         (ce_n_i),
    .oe_n_i         (oe_n_i),
    .we_n_i         (we_n_i),
    .array_data_i   (array_data_i),
    .rd_data_o      (rd_data_o),
    .rd_drive_o     (rd_drive_o)
);

// File: tb/sim_status_readout.sv
module sim_status_readout;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          busy_i = 1'b0;
    logic [DW-1:0] last_wr_data_i = '0;
    logic          ce_n_i = 1'b1;
    logic          oe_n_i = 1'b1;
    logic          we_n_i = 1'b1;
    logic [DW-1:0] array_data_i = '0;
    logic [DW-1:0] rd_data_o;
    logic          rd_drive_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference-model state.
    bit   prev_drv = 0;
    bit   have_tog = 0;
    bit   prev_tog = 0;
    bit   cur_tog  = 0;
    bit   idle_gap = 0;
    int   tog_hist[$];

    always #4 clk = ~clk;

    status_readout u0 (
        .clk            (clk),
        .rst            (rst),
        .busy_i         (busy_i),
        .last_wr_data_i (last_wr_data_i),
        .ce_n_i         (ce_n_i),
        .oe_n_i         (oe_n_i),
        .we_n_i         (we_n_i),
        .array_data_i   (array_data_i),
        .rd_data_o      (rd_data_o),
        .rd_drive_o     (rd_drive_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst) begin
            chk("R8 drive", int'(rd_drive_o), 0);
            chk("R8 data", int'(rd_data_o), 0);
            prev_drv = 0;
        end else begin
            bit drv;
            drv = !ce_n_i && !oe_n_i && we_n_i;
            chk("R1", int'(rd_drive_o), int'(drv));
            if (!drv) begin
                chk("R2", int'(rd_data_o), 0);
            end else if (!busy_i) begin
                chk("R3", int'(rd_data_o), int'(array_data_i));
                if (!prev_drv) idle_gap = 1;
            end else begin
                chk("R4", int'(rd_data_o[DW-1]), int'(!last_wr_data_i[DW-1]));
                if (!prev_drv) begin
                    if (have_tog)
                        chk(idle_gap ? "R7" : "R5", int'(rd_data_o[DW-2]), int'(!prev_tog));
                    prev_tog = rd_data_o[DW-2];
                    cur_tog  = rd_data_o[DW-2];
                    have_tog = 1;
                    idle_gap = 0;
                    tog_hist.push_back(int'(cur_tog));
                end else begin
                    chk("R6", int'(rd_data_o[DW-2]), int'(cur_tog));
                end
            end
            prev_drv = drv;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic rd(input int len, input logic [DW-1:0] arr);
        array_data_i = arr;
        ce_n_i = 0; oe_n_i = 0; we_n_i = 1;
        step(len);
        ce_n_i = 1; oe_n_i = 1;
        step(1);
    endtask

    initial begin
        step(3);
        rst = 0;
        step(1);

        // Idle reads and non-read strobe combinations.
        rd(2, 8'h5A);
        rd(1, 8'hC3);
        ce_n_i = 0; oe_n_i = 1; we_n_i = 1; array_data_i = 8'hFF; step(2);
        ce_n_i = 0; oe_n_i = 0; we_n_i = 0; step(2);
        ce_n_i = 1; oe_n_i = 0; we_n_i = 1; step(2);
        ce_n_i = 1; oe_n_i = 1; we_n_i = 1; step(1);

        // Busy with a last byte whose top bit is 1.
        busy_i = 1; last_wr_data_i = 8'hA5; step(1);
        rd(3, 8'h11);
        rd(1, 8'h22);
        rd(5, 8'h33);
        // Access ended by write-enable going low.
        ce_n_i = 0; oe_n_i = 0; step(2);
        we_n_i = 0; step(1);
        we_n_i = 1; ce_n_i = 1; oe_n_i = 1; step(1);

        // New last byte with top bit 0.
        last_wr_data_i = 8'h3C; step(1);
        rd(2, 8'h44);
        rd(4, 8'h55);

        // Program cycle finishes, so true data returns.
        busy_i = 0; step(1);
        rd(1, 8'h81);
        rd(3, 8'h7E);
        rd(2, 8'h00);

        // Busy again: sequence continues from before the idle reads.
        busy_i = 1; last_wr_data_i = 8'h80; step(1);
        rd(2, 8'h99);
        rd(1, 8'h98);
        rd(3, 8'h97);
        busy_i = 0; step(1);
        rd(1, 8'hE7);
        step(2);

        if (tog_hist.size() < 9) chk("R5 count", tog_hist.size(), 9);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule